// File: doc/BRIEF.md
# Fuse Key Load Controller

This controller brings a secret device key out of fuse storage and into a content-protection engine before any authentication starts. It does not handle the key itself. It drives short trigger pulses toward the key engine and watches two flags that come back: a completion flag and a key-good flag.

When a start request arrives and the controller is idle, it first looks at the engine flags. If both flags are already set, the key is in place and the run ends with success at once. Otherwise the controller pulses a load trigger and waits a bounded time for completion. A load that does not complete in time, or that completes with the good flag low, counts as a failed attempt. Each failed attempt is followed by a clear pulse, which makes the engine drop all of its load and fuse flags, and then a fresh try. The number of attempts is capped. A key that loads cleanly is followed by one pulse that tells the engine to send the public key on to the link side.

A mode input covers platforms where the key is loaded by hardware when the display leaves reset. In that mode a key that is not already in place is an immediate error.

Top module: `key_load_ctrl`

## Requirements
- R1: During and after reset, with no start request, busy_o, ok_o, err_o and all three trigger outputs are low.
- R2: A start_i seen while idle raises busy_o on the next cycle. busy_o stays high until the cycle in which exactly one of ok_o or err_o pulses for a single cycle. busy_o is low in the cycle after that pulse.
- R3: If eng_done_i and eng_good_i are both high when the controller checks them, the run ends with ok_o and no trigger pulse of any kind.
- R4: When the key is not yet in place, the controller pulses load_trig_o for one cycle and waits for eng_done_i. If eng_done_i arrives with eng_good_i high, send_trig_o pulses exactly once, and ok_o follows in the next cycle.
- R5: A completion seen with eng_good_i low counts as a failed attempt.
- R6: If eng_done_i does not appear within CLK_MHZ*WAIT_US cycles of waiting, the attempt fails. The clear pulse then comes exactly CLK_MHZ*WAIT_US+1 cycles after the load pulse.
- R7: Every failed attempt produces exactly one clear_trig_o pulse, after which the flags are checked again and a new attempt begins.
- R8: A run makes at most MAX_TRIES load attempts (default 5). After the last of them fails, err_o pulses and send_trig_o is never pulsed.
- R9: With legacy_mode_i high and the key not already in place, the run ends with err_o and no trigger pulse. With the key already in place, it ends with ok_o.
- R10: A start_i that arrives while busy_o is high has no effect. It causes no additional load and no second completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to bring the key into the engine |
| legacy_mode_i | input | 1 | Key must already be loaded by hardware; never trigger a load |
| eng_done_i | input | 1 | Engine reports that a load has completed |
| eng_good_i | input | 1 | Engine reports that the loaded key is valid |
| load_trig_o | output | 1 | One-cycle pulse that starts a fuse load |
| clear_trig_o | output | 1 | One-cycle pulse that clears the key and all engine flags |
| send_trig_o | output | 1 | One-cycle pulse that forwards the public key |
| busy_o | output | 1 | High while a run is in progress |
| ok_o | output | 1 | One-cycle pulse: the key is in place |
| err_o | output | 1 | One-cycle pulse: the run gave up |

## Verification
The bench goes after the retry count at both edges. Four failures followed by a good fifth attempt must end in success, and five failures must end in error. A design with an off-by-one attempt counter would stop one try early or make a sixth load. A completion flag left set from an earlier run while the good flag is low must still force a full load; a check on the completion flag alone would wrongly skip it. The hang case measures the distance from load pulse to clear pulse, which exposes a wait window that is one cycle short or long. Extra start pulses sent during a run expose a design that restarts or finishes twice.

// File: rtl/key_load_ctrl.sv
module key_load_ctrl #(
  parameter int CLK_MHZ   = 125,
  parameter int WAIT_US   = 500,
  parameter int MAX_TRIES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic legacy_mode_i,
  input  logic eng_done_i,
  input  logic eng_good_i,
  output logic load_trig_o,
  output logic clear_trig_o,
  output logic send_trig_o,
  output logic busy_o,
  output logic ok_o,
  output logic err_o
);
  localparam int TO = CLK_MHZ * WAIT_US;
  localparam int TW = $clog2(TO + 1);
  localparam int AW = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_LOAD, S_WAIT, S_CLEAR, S_SEND, S_OK, S_ERR
  } st_t;

  st_t st, nx;
  logic [TW-1:0] wcnt;
  logic [AW-1:0] tries;

  wire key_in_place = eng_done_i & eng_good_i;
  wire timed_out    = wcnt == TW'(TO - 1);
  wire last_try     = tries == AW'(MAX_TRIES - 1);

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (start_i) nx = S_CHECK;
      S_CHECK: if (key_in_place) nx = S_OK;
               else if (legacy_mode_i) nx = S_ERR;
               else nx = S_LOAD;
      S_LOAD:  nx = S_WAIT;
      S_WAIT:  if (eng_done_i) nx = eng_good_i ? S_SEND : S_CLEAR;
               else if (timed_out) nx = S_CLEAR;
      S_CLEAR: nx = last_try ? S_ERR : S_CHECK;
      S_SEND:  nx = S_OK;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wcnt  <= '0;
      tries <= '0;
    end else begin
      st    <= nx;
      wcnt  <= (st == S_WAIT) ? wcnt + 1'b1 : '0;
      if (st == S_IDLE)       tries <= '0;
      else if (st == S_CLEAR) tries <= tries + 1'b1;
    end
  end

  assign load_trig_o  = st == S_LOAD;
  assign clear_trig_o = st == S_CLEAR;
  assign send_trig_o  = st == S_SEND;
  assign ok_o         = st == S_OK;
  assign err_o        = st == S_ERR;
  assign busy_o       = st != S_IDLE;

  AST_OK_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) ok_o |=> !busy_o && !ok_o); // R2
  AST_ERR_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !busy_o && !err_o); // R2
  AST_BUSY_BY_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(start_i)); // R2
  AST_SEND_THEN_OK: assert property (@(posedge clk) disable iff (!rst_n) send_trig_o |=> ok_o); // R4
  AST_WAIT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT) |-> wcnt < TW'(TO)); // R6
  AST_TRIES_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) tries <= AW'(MAX_TRIES)); // R8
endmodule

// File: tb/key_load_ctrl_bench.sv
module key_load_ctrl_bench;
  localparam int CLK_MHZ = 125;
  localparam int WAIT_US = 1;
  localparam int TO      = CLK_MHZ * WAIT_US;
  localparam int LAT     = 3;

  logic clk = 0, rst_n = 0, start_i = 0, legacy_mode_i = 0;
  logic eng_done_i, eng_good_i;
  logic load_trig_o, clear_trig_o, send_trig_o, busy_o, ok_o, err_o;
  always #4 clk = ~clk;

  key_load_ctrl #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .MAX_TRIES(5)) u_key_load_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .legacy_mode_i(legacy_mode_i),
    .eng_done_i(eng_done_i), .eng_good_i(eng_good_i),
    .load_trig_o(load_trig_o), .clear_trig_o(clear_trig_o), .send_trig_o(send_trig_o),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o));

  // engine model
  logic seed = 0, pre_done = 0, pre_good = 0, hang = 0;
  int fail_n = 0;
  int n_load, n_clear, n_send, lat, cyc, t_load, gap;
  logic pend, good_next;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || seed) begin
      eng_done_i <= seed ? pre_done : 1'b0;
      eng_good_i <= seed ? pre_good : 1'b0;
      n_load <= 0; n_clear <= 0; n_send <= 0; pend <= 0; lat <= 0; good_next <= 0;
      t_load <= 0; gap <= 0;
    end else begin
      if (clear_trig_o) begin
        eng_done_i <= 0; eng_good_i <= 0; n_clear <= n_clear + 1; gap <= cyc - t_load;
      end
      if (load_trig_o) begin
        eng_done_i <= 0; eng_good_i <= 0; lat <= LAT; pend <= !hang;
        good_next <= (n_load >= fail_n); n_load <= n_load + 1; t_load <= cyc;
      end else if (pend) begin
        if (lat == 0) begin eng_done_i <= 1; eng_good_i <= good_next; pend <= 0; end
        else lat <= lat - 1;
      end
      if (send_trig_o) n_send <= n_send + 1;
    end
  end
  initial cyc = 0;

  int errors = 0, checks = 0;
  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fields: [19]pre_done [18]pre_good [17]legacy [16]hang [15:12]fail_n
  //         [11]exp_ok [10:8]loads [7]- [6:4]clears [3:1]- [0]sends
  localparam logic [19:0] VEC [0:9] = '{
    {4'b1100, 4'd0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0},  // R3 already loaded
    {4'b0000, 4'd0, 1'b1, 3'd1, 1'b0, 3'd0, 3'd0, 1'b1},  // R4 clean load
    {4'b0000, 4'd2, 1'b1, 3'd3, 1'b0, 3'd2, 3'd0, 1'b1},  // R5 R7 two bad
    {4'b0000, 4'd4, 1'b1, 3'd5, 1'b0, 3'd4, 3'd0, 1'b1},  // R8 good on last
    {4'b0000, 4'd5, 1'b0, 3'd5, 1'b0, 3'd5, 3'd0, 1'b0},  // R8 all bad
    {4'b0001, 4'd0, 1'b0, 3'd5, 1'b0, 3'd5, 3'd0, 1'b0},  // R6 hang
    {4'b0010, 4'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0},  // R9 legacy empty
    {4'b1110, 4'd0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0},  // R9 legacy loaded
    {4'b1000, 4'd0, 1'b1, 3'd1, 1'b0, 3'd0, 3'd0, 1'b1},  // R3 stale done only
    {4'b0100, 4'd0, 1'b1, 3'd1, 1'b0, 3'd0, 3'd0, 1'b1}   // R3 good only
  };

  bit got_ok, busy_gap;

  task automatic run(input int extra_starts);
    int n;
    @(negedge clk); seed = 1;
    @(negedge clk); seed = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o, "R2 busy after start", busy_o, 1);
    busy_gap = 0; n = 0;
    while (!(ok_o || err_o) && n < 3000) begin
      if (n < extra_starts) start_i = 1; else start_i = 0;
      if (!busy_o) busy_gap = 1;
      @(negedge clk); n++;
    end
    start_i = 0;
    got_ok = ok_o;
    chk(ok_o ^ err_o, "R2 one outcome pulse", {ok_o, err_o}, 1);
    @(negedge clk);
    chk(!busy_o && !ok_o && !err_o, "R2 pulse ends, idle", {busy_o, ok_o, err_o}, 0);
    chk(!busy_gap, "R2 busy held", busy_gap, 0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
      begin
        fail_n = 0;
        repeat (3) @(negedge clk);
        chk({busy_o, ok_o, err_o, load_trig_o, clear_trig_o, send_trig_o} == 0, "R1 reset outputs",
            {busy_o, ok_o, err_o, load_trig_o, clear_trig_o, send_trig_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk({busy_o, ok_o, err_o, load_trig_o, clear_trig_o, send_trig_o} == 0, "R1 idle outputs",
            {busy_o, ok_o, err_o, load_trig_o, clear_trig_o, send_trig_o}, 0);

        for (int i = 0; i < 10; i++) begin
          logic [19:0] v;
          v = VEC[i];
          pre_done = v[19]; pre_good = v[18]; legacy_mode_i = v[17]; hang = v[16];
          fail_n = int'(v[15:12]);
          run(0);
          chk(got_ok == v[11], $sformatf("R8 R9 outcome row %0d", i), got_ok, v[11]);
          chk(n_load == int'(v[10:8]), $sformatf("R4 R8 loads row %0d", i), n_load, v[10:8]);
          chk(n_clear == int'(v[6:4]), $sformatf("R7 clears row %0d", i), n_clear, v[6:4]);
          chk(n_send == int'(v[0]), $sformatf("R4 sends row %0d", i), n_send, v[0]);
          if (i == 5) chk(gap == TO + 1, "R6 timeout distance", gap, TO + 1);
        end

        // R10: start pulses during a run are ignored
        pre_done = 0; pre_good = 0; legacy_mode_i = 0; hang = 0; fail_n = 0;
        run(4);
        repeat (6) @(negedge clk);
        chk(!busy_o, "R10 no restart", busy_o, 0);
        chk(n_load == 1, "R10 single load", n_load, 1);
        chk(n_send == 1, "R10 single send", n_send, 1);

        // R5: bad key on first try, then good
        fail_n = 1;
        run(0);
        chk(got_ok && n_clear == 1 && n_load == 2, "R5 bad then good", n_load * 10 + n_clear, 21);
      end
    join_any
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule